// File: doc/BRIEF.md
# SD EDH CRC Regenerator

This block sits in a 10-bit standard-definition serial digital video datapath. It keeps two running CRCs for each field. One covers the active-picture region and the other covers the full-field region. An upstream timing decoder supplies a region flag for each.

When an error-detection ancillary packet arrives, the block rewrites that packet's six CRC words in place with the values from the field that just ended. It then replaces the packet checksum so that the packet stays consistent. The flag words inside the packet are never altered, and the block never creates a packet of its own.

The rewrite runs only when three conditions hold at once: the stream is standard definition, the global processing enable is high, and the active-low insertion control is low. In every other case the stream passes through unchanged, one clock later.

Top module: `edh_crc_regen`

## Requirements
- R1: `dout` and `dout_vld` are registered: each input word appears exactly one clock later, `dout_vld` copies `din_vld` one clock later, and reset (synchronous, active high) drives both to zero.
- R2: When `proc_en` is 0, or `crc_ins_n` is 1, or `sd_sel` is 0, every output word equals the input word one clock earlier, including the words of a packet.
- R3: Each CRC uses the polynomial x^16+x^12+x^5+1 (0x1021). It is fed bits 0 through 9 of each valid in-region word, in that order, one bit at a time, with feedback taken from CRC bit 15. It is preset to 0xFFFF on the first valid word of a region.
- R4: A region closes on the first valid word whose flag is low after valid words with the flag high. The CRC reached at that point is the value held for insertion, and its validity bit becomes 1. Before any region has closed since reset, the held CRC is 0 with validity 0.
- R5: A packet is recognised only when the valid words 000h, 3FFh, 3FFh are followed by a data ID of 1F4h. Words marked not valid are skipped. Every other data ID leaves the stream untouched.
- R6: User words 0, 1 and 2 carry the active-picture CRC, and user words 3, 4 and 5 carry the full-field CRC. Slice 0 holds CRC bits 5:0 and slice 1 holds bits 11:6; both sit in word bits 7:2. Slice 2 holds CRC bits 15:12 in word bits 5:2, with bits 7:6 set to 0. In every slice word, bit 1 is the validity bit, bit 0 is 0, bit 8 is the even parity of bits 7:0, and bit 9 is the inverse of bit 8.
- R7: User words from index 6 onward (the error flag words) leave the block unmodified.
- R8: The checksum word is the 9-bit sum of bits 8:0 of the data ID, the block-number word, the count word and every outgoing (rewritten) user word. Bit 9 of the checksum word is the inverse of its bit 8.
- R9: If a region closes on the same valid word that is its first CRC slot in the packet, the value inserted is the CRC just completed, not the previously held one.
- R10: The low 8 bits of the count word set the number of user words. With fewer than six user words, only the slots present are rewritten. With a count of 0, the word right after the count word is treated as the checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 10 | Incoming video word |
| din_vld | input | 1 | Qualifies `din` |
| pic_flag | input | 1 | Word lies in the active-picture CRC region |
| fld_flag | input | 1 | Word lies in the full-field CRC region |
| sd_sel | input | 1 | 1 = standard-definition stream |
| crc_ins_n | input | 1 | Insertion control, 0 enables rewriting |
| proc_en | input | 1 | Global processing enable |
| dout | output | 10 | Outgoing video word |
| dout_vld | output | 1 | Qualifies `dout` |

## Verification
Region closing and slot substitution can fall on the same word. This happens when the region flags stay high through the packet header and drop on the first user word. At that moment one CRC engine latches its final value while the packet editor is already substituting that CRC's first slice. The bench provokes this by opening both regions just before the preamble. It then expects the first active-picture slice and all later slices, including the full-field ones, to carry CRCs that also cover the header words. It also expects the checksum to be consistent with those rewritten slices.

// File: rtl/edh_pkg.sv
package edh_pkg;
  localparam int WORD_W = 10;
  localparam int CRC_W  = 16;
  localparam int SUM_W  = 9;
  localparam int CNT_W  = 8;
  localparam int SLICE_W = 6;

  typedef enum logic [2:0] {PK_IDLE, PK_DBN, PK_CNT, PK_USER, PK_SUM} pk_state_t;

  // Advance a CRC by one word, lowest bit first.
  function automatic logic [CRC_W-1:0] crc_feed(input logic [CRC_W-1:0] c,
                                                input logic [WORD_W-1:0] w,
                                                input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < WORD_W; i++) begin
      fb = r[CRC_W-1] ^ w[i];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    return r;
  endfunction

  // Pack one slice of a CRC into a protected 10-bit word.
  function automatic logic [WORD_W-1:0] crc_slice(input logic [CRC_W-1:0] c,
                                                  input logic ok,
                                                  input logic [1:0] part);
    logic [SLICE_W-1:0] p;
    logic [WORD_W-1:0] r;
    case (part)
      2'd0:    p = c[5:0];
      2'd1:    p = c[11:6];
      default: p = {2'b00, c[15:12]};
    endcase
    r    = {2'b00, p, ok, 1'b0};
    r[8] = ^r[7:0];
    r[9] = ~r[8];
    return r;
  endfunction
endpackage

// File: rtl/edh_region_crc.sv
module edh_region_crc
  import edh_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld,
  input  logic              flag,
  input  logic [WORD_W-1:0] word,
  output logic [CRC_W-1:0]  crc_fwd,
  output logic              ok_fwd
);
  logic             in_reg;
  logic [CRC_W-1:0] run;
  logic [CRC_W-1:0] hold;
  logic             ok;
  logic             close;

  assign close = vld && !flag && in_reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_reg <= 1'b0;
      run    <= CRC_INIT;
      hold   <= '0;
      ok     <= 1'b0;
    end else if (vld) begin
      in_reg <= flag;
      if (flag) run <= crc_feed(in_reg ? run : CRC_INIT, word, CRC_POLY);
      if (close) begin
        hold <= run;
        ok   <= 1'b1;
      end
    end
  end

  // Forward the just-finished value when the region closes this word.
  assign crc_fwd = close ? run : hold;
  assign ok_fwd  = close | ok;
endmodule

// File: rtl/edh_pkt_editor.sv
module edh_pkt_editor
  import edh_pkg::*;
#(
  parameter logic [WORD_W-1:0] DID_CODE  = 10'h1F4,
  parameter int                CRC_SLOTS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld,
  input  logic              en,
  input  logic [WORD_W-1:0] word,
  input  logic [CRC_W-1:0]  ap_crc,
  input  logic              ap_ok,
  input  logic [CRC_W-1:0]  ff_crc,
  input  logic              ff_ok,
  output logic [WORD_W-1:0] word_out,
  output logic              sub_crc,
  output logic              sub_sum
);
  localparam int                ALL_SLOTS = 2 * CRC_SLOTS;
  localparam logic [WORD_W-1:0] PRE_LO    = '0;
  localparam logic [WORD_W-1:0] PRE_HI    = '1;

  pk_state_t         state;
  logic [SUM_W-1:0]  sum;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  idx;
  logic [WORD_W-1:0] h0, h1, h2;
  logic              hdr_hit;
  logic              sel_ff;
  logic [CNT_W-1:0]  part_idx;
  logic [CRC_W-1:0]  pick_crc;
  logic              pick_ok;

  assign hdr_hit  = (h2 == PRE_LO) && (h1 == PRE_HI) && (h0 == PRE_HI) && (word == DID_CODE);
  assign sel_ff   = idx >= CNT_W'(CRC_SLOTS);
  assign part_idx = sel_ff ? idx - CNT_W'(CRC_SLOTS) : idx;
  assign pick_crc = sel_ff ? ff_crc : ap_crc;
  assign pick_ok  = sel_ff ? ff_ok : ap_ok;
  assign sub_crc  = vld && en && (state == PK_USER) && (idx < CNT_W'(ALL_SLOTS));
  assign sub_sum  = vld && en && (state == PK_SUM);

  always_comb begin
    word_out = word;
    if (sub_crc)      word_out = crc_slice(pick_crc, pick_ok, part_idx[1:0]);
    else if (sub_sum) word_out = {~sum[SUM_W-1], sum};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PK_IDLE;
      sum   <= '0;
      cnt   <= '0;
      idx   <= '0;
      h0    <= '0;
      h1    <= '0;
      h2    <= '0;
    end else if (vld) begin
      h2 <= h1;
      h1 <= h0;
      h0 <= word;
      case (state)
        PK_IDLE: if (hdr_hit) begin
          sum   <= word[SUM_W-1:0];
          state <= PK_DBN;
        end
        PK_DBN: begin
          sum   <= sum + word[SUM_W-1:0];
          state <= PK_CNT;
        end
        PK_CNT: begin
          sum   <= sum + word[SUM_W-1:0];
          cnt   <= word[CNT_W-1:0];
          idx   <= '0;
          state <= (word[CNT_W-1:0] == '0) ? PK_SUM : PK_USER;
        end
        PK_USER: begin
          sum <= sum + word_out[SUM_W-1:0];
          idx <= idx + 1'b1;
          if (idx == cnt - 1'b1) state <= PK_SUM;
        end
        default: state <= PK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/edh_crc_regen.sv
module edh_crc_regen
  import edh_pkg::*;
#(
  parameter logic [CRC_W-1:0]  CRC_POLY  = 16'h1021,
  parameter logic [CRC_W-1:0]  CRC_INIT  = 16'hFFFF,
  parameter logic [WORD_W-1:0] DID_CODE  = 10'h1F4,
  parameter int                CRC_SLOTS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] din,
  input  logic              din_vld,
  input  logic              pic_flag,
  input  logic              fld_flag,
  input  logic              sd_sel,
  input  logic              crc_ins_n,
  input  logic              proc_en,
  output logic [WORD_W-1:0] dout,
  output logic              dout_vld
);
  localparam int N_REG = 2;  // 0: active picture, 1: full field

  logic [N_REG-1:0] flags;
  logic [CRC_W-1:0] rcrc [N_REG];
  logic             rok  [N_REG];
  logic             en;
  logic [WORD_W-1:0] edited;
  logic             sub_crc;
  logic             sub_sum;

  assign flags = {fld_flag, pic_flag};
  assign en    = proc_en && !crc_ins_n && sd_sel;

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    edh_region_crc #(.CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT)) u_crc (
      .clk(clk), .rst(rst), .vld(din_vld), .flag(flags[g]), .word(din),
      .crc_fwd(rcrc[g]), .ok_fwd(rok[g])
    );
  end

  edh_pkt_editor #(.DID_CODE(DID_CODE), .CRC_SLOTS(CRC_SLOTS)) u_edit (
    .clk(clk), .rst(rst), .vld(din_vld), .en(en), .word(din),
    .ap_crc(rcrc[0]), .ap_ok(rok[0]), .ff_crc(rcrc[1]), .ff_ok(rok[1]),
    .word_out(edited), .sub_crc(sub_crc), .sub_sum(sub_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout     <= edited;
      dout_vld <= din_vld;
    end
  end
endmodule

// File: rtl/edh_regen_chk.sv
module edh_regen_chk (
  input logic       clk,
  input logic       rst,
  input logic [9:0] din,
  input logic       din_vld,
  input logic       sd_sel,
  input logic       crc_ins_n,
  input logic       proc_en,
  input logic [9:0] dout,
  input logic       dout_vld,
  input logic       sub_crc,
  input logic       sub_sum
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  // R1
  p_vld_follow_r1: assert property (@(posedge clk) disable iff (rst)
    armed |-> dout_vld == $past(din_vld));
  p_sub_on_valid_r1: assert property (@(posedge clk) disable iff (rst)
    (sub_crc || sub_sum) |-> din_vld);
  // R2
  p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!proc_en || crc_ins_n || !sd_sel) |-> dout == $past(din));
  // R7
  p_kept_r7: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(sub_crc) && !$past(sub_sum) |-> dout == $past(din));
  // R6
  p_slice_code_r6: assert property (@(posedge clk) disable iff (rst)
    armed && $past(sub_crc) |->
      (dout[9] == !dout[8]) && (dout[8] == ^dout[7:0]) && !dout[0]);
  // R8
  p_sum_code_r8: assert property (@(posedge clk) disable iff (rst)
    armed && $past(sub_sum) |-> dout[9] == !dout[8]);
endmodule

bind edh_crc_regen edh_regen_chk u_chk (
  .clk(clk), .rst(rst), .din(din), .din_vld(din_vld), .sd_sel(sd_sel),
  .crc_ins_n(crc_ins_n), .proc_en(proc_en), .dout(dout), .dout_vld(dout_vld),
  .sub_crc(sub_crc), .sub_sum(sub_sum)
);

// File: tb/tb_edh_crc_regen.sv
`timescale 1ns/1ps
module tb_edh_crc_regen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] din = '0;
  logic       din_vld = 1'b0, pic_flag = 1'b0, fld_flag = 1'b0;
  logic       sd_sel = 1'b1, crc_ins_n = 1'b0, proc_en = 1'b1;
  logic [9:0] dout;
  logic       dout_vld;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] m_ap = '0, m_ff = '0, m_runa = '0, m_runf = '0;
  bit m_ap_ok = 0, m_ff_ok = 0, m_ina = 0, m_inf = 0;

  always #2 clk = ~clk;

  edh_crc_regen dut (.clk(clk), .rst(rst), .din(din), .din_vld(din_vld),
    .pic_flag(pic_flag), .fld_flag(fld_flag), .sd_sel(sd_sel),
    .crc_ins_n(crc_ins_n), .proc_en(proc_en), .dout(dout), .dout_vld(dout_vld));

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [9:0] w);
    logic [15:0] r = c;
    for (int i = 0; i < 10; i++) begin
      logic fb = r[15] ^ w[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic logic [9:0] slice(input logic [15:0] c, input bit ok, input int part);
    logic [5:0] p;
    logic [9:0] r;
    p = (part == 0) ? c[5:0] : (part == 1) ? c[11:6] : {2'b00, c[15:12]};
    r = {2'b00, p, ok, 1'b0};
    r[8] = ^r[7:0];
    r[9] = ~r[8];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [10:0] act, input logic [10:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Region model from the requirements (R3, R4).
  task automatic mdl(input logic [9:0] w, input bit v, input bit a, input bit f);
    if (!v) return;
    if (!f && m_inf) begin m_ff = m_runf; m_ff_ok = 1; end
    if (!a && m_ina) begin m_ap = m_runa; m_ap_ok = 1; end
    if (f) m_runf = crc_step(m_inf ? m_runf : 16'hFFFF, w);
    if (a) m_runa = crc_step(m_ina ? m_runa : 16'hFFFF, w);
    m_inf = f;
    m_ina = a;
  endtask

  // Drive at a falling edge, sample at the next falling edge (R1 latency).
  task automatic put(input logic [9:0] w, input bit v, input bit a, input bit f,
                     input logic [9:0] exp, input string tag);
    din = w; din_vld = v; pic_flag = a; fld_flag = f;
    @(negedge clk);
    check(dout == exp && dout_vld == v, tag, {dout_vld, dout}, {v, exp});
  endtask

  task automatic send_field(input int n, input int seed);
    for (int k = 0; k < n; k++) begin
      logic [9:0] w = 10'h040 + 10'((seed * 37 + k * 13) % 896);
      bit f = (k >= 2) && (k < n - 2);
      bit a = (k >= 4) && (k < n - 4);
      if (k % 5 == 3) put(10'h3FF, 0, ~a, ~f, 10'h3FF, "R1 idle word, valid low");
      mdl(w, 1, a, f);
      put(w, 1, a, f, w, "R3 field word unchanged");
    end
  endtask

  task automatic send_edh(input logic [7:0] dc, input logic [9:0] did, input bit en_exp,
                          input bit hdr_f, input string crc_tag);
    logic [9:0] hdr [6];
    logic [8:0] s = '0;
    logic [9:0] w, e;
    bit hit = (did == 10'h1F4) && en_exp;
    hdr = '{10'h000, 10'h3FF, 10'h3FF, did, 10'h200, {2'b10, dc}};
    for (int i = 0; i < 6; i++) begin
      mdl(hdr[i], 1, hdr_f, hdr_f);
      if (i >= 3) s = s + hdr[i][8:0];
      put(hdr[i], 1, hdr_f, hdr_f, hdr[i], "R5 header word");
    end
    for (int k = 0; k < int'(dc); k++) begin
      w = 10'h2A0 + 10'(k);
      mdl(w, 1, 0, 0);
      e = w;
      if (hit && k < 6) e = (k < 3) ? slice(m_ap, m_ap_ok, k) : slice(m_ff, m_ff_ok, k - 3);
      s = s + e[8:0];
      put(w, 1, 0, 0, e, (k < 6) ? crc_tag : "R7 flag word untouched");
    end
    w = 10'h155;
    mdl(w, 1, 0, 0);
    e = hit ? {~s[8], s} : w;
    put(w, 1, 0, 0, e, "R8/R10 checksum word");
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(dout == 10'h000 && dout_vld == 1'b0, "R1 reset outputs", {dout_vld, dout}, 11'h000);
    rst = 1'b0;
  endtask

  task automatic t_before_field();  // R4: nothing closed yet
    send_edh(8'h10, 10'h1F4, 1, 0, "R4/R6 CRC word before any field");
  endtask

  task automatic t_field_packet();
    send_field(40, 1);
    send_edh(8'h10, 10'h1F4, 1, 0, "R3/R4/R6 CRC word");
    send_field(25, 7);
    send_edh(8'h10, 10'h1F4, 1, 0, "R3/R4/R6 CRC word second field");
  endtask

  task automatic t_bypass();
    proc_en = 1'b0;
    send_field(20, 3);
    send_edh(8'h10, 10'h1F4, 0, 0, "R2 proc_en low");
    proc_en = 1'b1; crc_ins_n = 1'b1;
    send_edh(8'h10, 10'h1F4, 0, 0, "R2 crc_ins_n high");
    crc_ins_n = 1'b0; sd_sel = 1'b0;
    send_edh(8'h10, 10'h1F4, 0, 0, "R2 sd_sel low");
    sd_sel = 1'b1;
  endtask

  task automatic t_foreign_did();
    send_field(18, 11);
    send_edh(8'h10, 10'h1F5, 1, 0, "R5 foreign ID unchanged");
    send_edh(8'h10, 10'h1F4, 1, 0, "R5 real packet after foreign");
  endtask

  task automatic t_short();
    send_field(16, 5);
    send_edh(8'h04, 10'h1F4, 1, 0, "R10 short packet CRC word");
    send_edh(8'h00, 10'h1F4, 1, 0, "R10 empty packet");
  endtask

  task automatic t_coincide();
    for (int k = 0; k < 3; k++) begin
      logic [9:0] w = 10'h0A0 + 10'(k * 29);
      mdl(w, 1, 1, 1);
      put(w, 1, 1, 1, w, "R9 opening word");
    end
    send_edh(8'h10, 10'h1F4, 1, 1, "R9 forwarded CRC word");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_before_field();
    t_field_packet();
    t_bypass();
    t_foreign_did();
    t_short();
    t_coincide();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule